// File: doc/BRIEF.md
# Chained FIFO Depth Expansion Controller

This block is the per-device control that lets several FIFO devices be linked in a ring to act as one deeper FIFO. Each device passes a write token and a read token around the ring. Only the device that holds the write token accepts writes. Only the device that holds the read token accepts reads. When a device writes its last memory location, it gives up the write token and sends a one-cycle pulse on its write expansion output. The next device takes the token when it sees that pulse. The read side works the same way on the read clock.

An active-low strap marks the first device in the ring. That device starts with both tokens, and every other device starts with none. The memory array and the shared data buses lie outside this block.

When the chain strap is low, the device runs standalone or side by side for width expansion. In that mode it ignores the expansion inputs, passes the requests straight through as enables, and drives the write expansion output with the half-full indication.

Top module: `dx_chain_ctrl`

## Requirements
- R1: After reset in chain mode, a device whose first strap `first_n_i` is 0 holds both tokens, and a device whose strap is 1 holds neither.
- R2: In chain mode, `wr_en_o` equals `wr_req_i` while the device holds the write token, and is 0 otherwise.
- R3: In chain mode, `rd_en_o` equals `rd_req_i` while the device holds the read token, and is 0 otherwise.
- R4: In chain mode, an accepted write with `wr_last_i` high makes `wxo_o` go high for exactly the next write clock cycle. The write token is released at that same edge.
- R5: In chain mode, an accepted read with `rd_last_i` high makes `rxo_o` go high for exactly the next read clock cycle. The read token is released at that same edge.
- R6: In chain mode, a high `wxi_i` seen at a write clock edge gives the device the write token from that edge on.
- R7: In chain mode, a high `rxi_i` seen at a read clock edge gives the device the read token from that edge on.
- R8: In standalone mode (`chain_i` = 0), `wr_en_o` follows `wr_req_i`, `rd_en_o` follows `rd_req_i`, `rxo_o` is 0 and `wxi_i`/`rxi_i` have no effect.
- R9: In standalone mode, `wxo_o` equals `half_full_i`. In chain mode, `wxo_o` does not depend on `half_full_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chain_i | input | 1 | Static strap: 1 = ring mode, 0 = standalone |
| first_n_i | input | 1 | Static strap: 0 = first device in the ring |
| wxi_i | input | 1 | Write token pulse from the previous device |
| rxi_i | input | 1 | Read token pulse from the previous device |
| wr_req_i | input | 1 | Write request |
| wr_last_i | input | 1 | The requested write targets the last location |
| rd_req_i | input | 1 | Read request |
| rd_last_i | input | 1 | The requested read targets the last location |
| half_full_i | input | 1 | Half-full indication from the flag logic |
| wr_en_o | output | 1 | Qualified write enable to the local memory |
| rd_en_o | output | 1 | Qualified read enable to the local memory |
| wxo_o | output | 1 | Write token pulse (ring) or half-full (standalone) |
| rxo_o | output | 1 | Read token pulse (ring) |

## Verification
A lost or duplicated token shows up at the enables in the first cycle that a request reaches the affected device. Two devices would then accept at once, or none would. A pulse that is missing or stretched shows at the expansion output on the cycle after the last-location access, and it skews the next device's enable one edge later. The bench runs two devices in a ring on unrelated clocks and compares every enable and pulse in every cycle against a token model.

// File: rtl/dx_pkg.sv
package dx_pkg;
  typedef enum logic {MODE_SOLO = 1'b0, MODE_CHAIN = 1'b1} dx_mode_e;
  localparam int unsigned DX_SIDES = 2;  // 0: write side, 1: read side
endpackage

// File: rtl/dx_token_stage.sv
module dx_token_stage
  import dx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  dx_mode_e mode_i,
  input  logic     first_i,
  input  logic     exp_i,
  input  logic     req_i,
  input  logic     last_i,
  output logic     en_o,
  output logic     pulse_o
);
  logic chain, tok_q, pulse_q, pulse_d;

  assign chain   = (mode_i == MODE_CHAIN);
  assign en_o    = req_i & (tok_q | ~chain);
  assign pulse_d = chain & en_o & last_i;
  assign pulse_o = pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tok_q   <= first_i;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      if (chain) begin
        if (exp_i)        tok_q <= 1'b1;  // arrival wins
        else if (pulse_d) tok_q <= 1'b0;
      end
    end
  end

  // R4 R5: pulse is one cycle wide
  assert_pulse_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);
  // R4 R5: last access in chain mode yields a pulse next cycle
  assert_pulse_after_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain && en_o && last_i) |=> pulse_q);
  // R6 R7: incoming pulse grants the token
  assert_token_taken_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain && exp_i) |=> tok_q);
  // R8: no pulses while standalone
  assert_solo_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chain |-> !pulse_q);
endmodule

// File: rtl/dx_chain_ctrl.sv
module dx_chain_ctrl
  import dx_pkg::*;
(
  input  logic wclk_i,
  input  logic rclk_i,
  input  logic rst_ni,
  input  logic chain_i,
  input  logic first_n_i,
  input  logic wxi_i,
  input  logic rxi_i,
  input  logic wr_req_i,
  input  logic wr_last_i,
  input  logic rd_req_i,
  input  logic rd_last_i,
  input  logic half_full_i,
  output logic wr_en_o,
  output logic rd_en_o,
  output logic wxo_o,
  output logic rxo_o
);
  dx_mode_e mode;
  logic [DX_SIDES-1:0] clk_v, exp_v, req_v, last_v, en_v, pulse_v;

  assign mode   = chain_i ? MODE_CHAIN : MODE_SOLO;
  assign clk_v  = {rclk_i, wclk_i};
  assign exp_v  = {rxi_i, wxi_i};
  assign req_v  = {rd_req_i, wr_req_i};
  assign last_v = {rd_last_i, wr_last_i};

  for (genvar s = 0; s < DX_SIDES; s++) begin : g_side
    dx_token_stage u_stage (
      .clk_i   (clk_v[s]),
      .rst_ni  (rst_ni),
      .mode_i  (mode),
      .first_i (~first_n_i),
      .exp_i   (exp_v[s]),
      .req_i   (req_v[s]),
      .last_i  (last_v[s]),
      .en_o    (en_v[s]),
      .pulse_o (pulse_v[s])
    );
  end

  assign wr_en_o = en_v[0];
  assign rd_en_o = en_v[1];
  assign wxo_o   = chain_i ? pulse_v[0] : half_full_i;
  assign rxo_o   = chain_i & pulse_v[1];

  // R9: standalone output mirrors half-full
  assert_solo_half_full_R9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !chain_i |-> (wxo_o == half_full_i));
endmodule

// File: tb/dx_chain_ctrl_test.sv
module dx_chain_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic chain = 1, solo_w = 0, solo_r = 0, hf = 0;
  logic [1:0] wr_req = 0, wr_last = 0, rd_req = 0, rd_last = 0;
  logic [1:0] wr_en, rd_en, wxo, rxo;
  logic uut_wxi, uut_rxi;
  int errors = 0, checks = 0;
  bit done = 0;
  bit [1:0] tw, tr, pw, pr;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  assign uut_wxi = chain ? wxo[1] : solo_w;
  assign uut_rxi = chain ? rxo[1] : solo_r;

  dx_chain_ctrl uut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .chain_i(chain), .first_n_i(1'b0),
    .wxi_i(uut_wxi), .rxi_i(uut_rxi), .wr_req_i(wr_req[0]), .wr_last_i(wr_last[0]),
    .rd_req_i(rd_req[0]), .rd_last_i(rd_last[0]), .half_full_i(hf),
    .wr_en_o(wr_en[0]), .rd_en_o(rd_en[0]), .wxo_o(wxo[0]), .rxo_o(rxo[0]));

  dx_chain_ctrl dev1 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .chain_i(chain), .first_n_i(1'b1),
    .wxi_i(wxo[0]), .rxi_i(rxo[0]), .wr_req_i(wr_req[1]), .wr_last_i(wr_last[1]),
    .rd_req_i(rd_req[1]), .rd_last_i(rd_last[1]), .half_full_i(hf),
    .wr_en_o(wr_en[1]), .rd_en_o(rd_en[1]), .wxo_o(wxo[1]), .rxo_o(rxo[1]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [1:0] next_tok(bit [1:0] tok, bit [1:0] pulse, bit [1:0] pl);
    bit [1:0] n;
    for (int d = 0; d < 2; d++) n[d] = pulse[1-d] ? 1'b1 : (pl[d] ? 1'b0 : tok[d]);
    return n;
  endfunction

  task automatic do_reset();
    rst_n = 0; wr_req = 0; rd_req = 0; wr_last = 0; rd_last = 0;
    #(3*CLK_PERIOD);
    @(negedge wclk); rst_n = 1;
    tw = 2'b01; tr = 2'b01; pw = 0; pr = 0;
  endtask

  task automatic run_w(input int n);
    bit [1:0] ee, pl;
    for (int k = 0; k < n; k++) begin
      @(negedge wclk);
      wr_req = 2'($urandom); wr_last = 2'($urandom % 3 == 0 ? 2'b11 : 2'b00) ^ 2'($urandom);
      hf = 1'($urandom); solo_w = 1'($urandom);
      #1;
      if (chain) begin
        ee = wr_req & tw;
        chk(wr_en == ee, "R2", wr_en, ee);
        chk(wxo == pw, "R4 R6 R9", wxo, pw);
        pl = ee & wr_last;
        tw = next_tok(tw, pw, pl);
        pw = pl;
      end else begin
        chk(wr_en == wr_req, "R8", wr_en, wr_req);
        chk(wxo == {hf, hf}, "R9", wxo, {hf, hf});
      end
    end
  endtask

  task automatic run_r(input int n);
    bit [1:0] ee, pl;
    for (int k = 0; k < n; k++) begin
      @(negedge rclk);
      rd_req = 2'($urandom); rd_last = 2'($urandom % 3 == 0 ? 2'b11 : 2'b00) ^ 2'($urandom);
      solo_r = 1'($urandom);
      #1;
      if (chain) begin
        ee = rd_req & tr;
        chk(rd_en == ee, "R3", rd_en, ee);
        chk(rxo == pr, "R5 R7", rxo, pr);
        pl = ee & rd_last;
        tr = next_tok(tr, pr, pl);
        pr = pl;
      end else begin
        chk(rd_en == rd_req, "R8", rd_en, rd_req);
        chk(rxo == 2'b00, "R8", rxo, 0);
      end
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    chain = 1;
    do_reset();
    // R1: first device holds both tokens, the other none
    wr_req = 2'b11; rd_req = 2'b11; #1;
    chk(wr_en == 2'b01, "R1", wr_en, 1);
    chk(rd_en == 2'b01, "R1", rd_en, 1);
    chk(wxo == 2'b00 && rxo == 2'b00, "R1", {wxo, rxo}, 0);
    // R4 R6 directed: last write on uut passes the token to dev1
    @(negedge wclk); wr_req = 2'b11; wr_last = 2'b01; #1;
    chk(wr_en == 2'b01, "R2", wr_en, 1);
    @(negedge wclk); wr_last = 2'b00; #1;
    chk(wxo == 2'b01, "R4", wxo, 1);
    chk(wr_en == 2'b00, "R4", wr_en, 0);
    @(negedge wclk); #1;
    chk(wxo == 2'b00, "R4", wxo, 0);
    chk(wr_en == 2'b10, "R6", wr_en, 2);
    tw = 2'b10; pw = 0;
    fork run_w(400); run_r(300); join

    chain = 0;
    do_reset();
    fork run_w(200); run_r(150); join

    chain = 1;
    do_reset();
    fork run_w(300); run_r(220); join

    done = 1;
    summary();
    $finish;
  end
endmodule